// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block turns a stream of command bytes from a byte-wide host FIFO into register-file accesses. The upper four bits of each byte select an operation. The lower four bits carry a 4-bit payload. An 8-bit register address is built from two separate nibble commands. Each 8-bit write datum is built from a low-nibble command and a high-nibble command, and the high-nibble command commits the write. Several data bytes may follow a single address phase; the block numbers them with a byte index so that the register file can place each byte of a wider value.

A read command returns the byte at the current address on an output byte stream with a valid/ready handshake. Its auto-incrementing variant advances the address after the read, so a run of reads walks through consecutive addresses without a new address phase. Two 24-bit capture positions, the trigger position and then the stop position, are mapped as six consecutive read-only bytes. Each position is returned least significant byte first. All other addresses are read from the external register file through a combinational read port.

Top module: `nibcmd_regif`

## Requirements
- R1: After reset, `out_valid` and `wr_en` are low and `cmd_ready` is high.
- R2: Opcode 0x0 (command bits 7:4) loads the command's bits 3:0 into address bits 3:0. Opcode 0x1 loads them into address bits 7:4. The other address half is kept in both cases.
- R3: Opcode 0x2 stores a low data nibble. Opcode 0x3 commits a write in the same cycle it is accepted: `wr_en` is high, `wr_addr` is the current address, and `wr_data` is {this nibble, last stored low nibble}.
- R4: `wr_idx` becomes 0 on every accepted opcode 0x1 and rises by one, modulo 2^IDX_W, after every committed write.
- R5: Opcode 0x4 places the byte at the current address on `out_data`, with `out_valid` high, in the cycle after acceptance. The address does not change.
- R6: Opcode 0x5 behaves as opcode 0x4 and then increments the address, so that 0xFF wraps to 0x00.
- R7: Addresses POS_BASE to POS_BASE+5 (POS_BASE defaults to 0x08) read trigger position bytes 0, 1, 2 and then stop position bytes 0, 1, 2, least significant byte first. All other addresses return `rd_data` for `rd_addr`, which equals the current address.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds and `cmd_ready` is low for read opcodes. A new read is accepted in the same cycle the pending byte is taken.
- R9: Opcodes 0x6 to 0xF are consumed and have no effect: no write, no output byte, and no change to the address.
- R10: Non-read commands are accepted even while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Opcode in bits 7:4, nibble in bits 3:0 |
| cmd_ready | output | 1 | Command byte consumed this cycle |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Write address |
| wr_idx | output | IDX_W | Byte index within the current address phase |
| wr_data | output | 8 | Write byte |
| rd_addr | output | 8 | Register file read address (current address) |
| rd_data | input | 8 | Register file read data, combinational |
| trig_pos | input | POS_W | Trigger position |
| stop_pos | input | POS_W | Stop position |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Read byte taken |
| out_data | output | 8 | Read byte |

## Verification
Two functions can fall in one cycle. A held read byte can drain while the next read command is being accepted, or it can drain while a non-read command changes the address that the following read will use. The bench provokes both cases with back-to-back read commands, walks through the position window, and runs a long random phase in which `out_ready` and the opcode mix are both randomized. A behavioural model predicts `cmd_ready`, the write port and every output byte cycle by cycle. A byte that is lost, duplicated or read from a stale address is therefore reported as an order or value mismatch.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

   typedef enum logic [3:0] {
      OP_ADDR_LO    = 4'h0,
      OP_ADDR_HI    = 4'h1,
      OP_DATA_LO    = 4'h2,
      OP_DATA_HI_WR = 4'h3,
      OP_READ       = 4'h4,
      OP_READ_INC   = 4'h5
   } nib_op_e;

   typedef struct packed {
      logic       addr_lo;
      logic       addr_hi;
      logic       data_lo;
      logic       data_hi;
      logic       rd;
      logic       rd_inc;
      logic [3:0] nib;
   } cmd_dec_t;

endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode
   import nibcmd_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_dec_t   dec
);

   always_comb begin
      dec     = '0;
      dec.nib = cmd_byte[3:0];
      case (cmd_byte[7:4])
         OP_ADDR_LO:    dec.addr_lo = 1'b1;
         OP_ADDR_HI:    dec.addr_hi = 1'b1;
         OP_DATA_LO:    dec.data_lo = 1'b1;
         OP_DATA_HI_WR: dec.data_hi = 1'b1;
         OP_READ:       dec.rd      = 1'b1;
         OP_READ_INC:   dec.rd_inc  = 1'b1;
         default:       ;
      endcase
   end

endmodule

// File: rtl/nibcmd_assembler.sv
module nibcmd_assembler
   import nibcmd_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_dec_t         dec,
   input  logic             acc,
   output logic [7:0]       cur_addr,
   output logic             wr_en,
   output logic [7:0]       wr_addr,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data
);

   logic [7:0]       addr_q;
   logic [3:0]       lo_q;
   logic [IDX_W-1:0] idx_q;
   logic             any_op;

   assign any_op = dec.addr_lo | dec.addr_hi | dec.data_lo |
                   dec.data_hi | dec.rd | dec.rd_inc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         lo_q   <= '0;
         idx_q  <= '0;
      end else if (acc) begin
         if (dec.addr_lo) addr_q[3:0] <= dec.nib;
         if (dec.addr_hi) begin
            addr_q[7:4] <= dec.nib;
            idx_q       <= '0;
         end
         if (dec.data_lo) lo_q <= dec.nib;
         if (dec.data_hi) idx_q <= idx_q + 1'b1;
         if (dec.rd_inc)  addr_q <= addr_q + 8'd1;
      end
   end

   assign cur_addr = addr_q;
   assign wr_en    = acc & dec.data_hi;
   assign wr_addr  = addr_q;
   assign wr_idx   = idx_q;
   assign wr_data  = {dec.nib, lo_q};

   // R6
   rd_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dec.rd_inc) |=> (cur_addr == $past(cur_addr) + 8'd1));

   // R9
   illegal_op_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !any_op) |=> $stable(cur_addr));

   // R4
   idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && dec.addr_hi) |=> (wr_idx == '0));

endmodule

// File: rtl/nibcmd_pos_window.sv
module nibcmd_pos_window #(
   parameter int       POS_W      = 24,
   parameter bit [7:0] POS_BASE   = 8'h08,
   parameter bit       POS_ENABLE = 1'b1
) (
   input  logic [7:0]       addr,
   input  logic [POS_W-1:0] trig_pos,
   input  logic [POS_W-1:0] stop_pos,
   input  logic [7:0]       file_data,
   output logic [7:0]       byte_out
);

   localparam int POS_BYTES = POS_W / 8;
   localparam int WIN       = 2 * POS_BYTES;

   if (POS_W % 8 != 0 || POS_W < 8) begin : g_bad_w
      $error("POS_W must be a positive multiple of 8");
   end
   if (int'(POS_BASE) + WIN > 256) begin : g_bad_base
      $error("position window must not wrap the address space");
   end

   if (POS_ENABLE) begin : g_win
      logic [WIN-1:0] hit;
      logic [7:0]     term [WIN];
      logic [7:0]     pos_byte;

      for (genvar k = 0; k < WIN; k++) begin : g_byte
         localparam bit [7:0] ADDR_K = 8'(int'(POS_BASE) + k);
         assign hit[k] = (addr == ADDR_K);
         if (k < POS_BYTES) begin : g_trig
            assign term[k] = hit[k] ? trig_pos[8*k +: 8] : 8'h00;
         end else begin : g_stop
            assign term[k] = hit[k] ? stop_pos[8*(k-POS_BYTES) +: 8] : 8'h00;
         end
      end

      always_comb begin
         pos_byte = 8'h00;
         for (int k = 0; k < WIN; k++) pos_byte = pos_byte | term[k];
      end

      assign byte_out = (|hit) ? pos_byte : file_data;
   end else begin : g_nowin
      assign byte_out = file_data;
   end

endmodule

// File: rtl/nibcmd_out_stage.sv
module nibcmd_out_stage (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_data,
   input  logic       out_ready,
   output logic       can_load,
   output logic       out_valid,
   output logic [7:0] out_data
);

   logic       vld_q;
   logic [7:0] dat_q;

   assign can_load = !vld_q || out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (load) begin
         vld_q <= 1'b1;
         dat_q <= load_data;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign out_valid = vld_q;
   assign out_data  = dat_q;

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/nibcmd_regif.sv
module nibcmd_regif
   import nibcmd_pkg::*;
#(
   parameter int       IDX_W      = 3,
   parameter int       POS_W      = 24,
   parameter bit [7:0] POS_BASE   = 8'h08,
   parameter bit       POS_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_data,
   output logic             cmd_ready,
   output logic             wr_en,
   output logic [7:0]       wr_addr,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [7:0]       rd_addr,
   input  logic [7:0]       rd_data,
   input  logic [POS_W-1:0] trig_pos,
   input  logic [POS_W-1:0] stop_pos,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data
);

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must lie in 1..8");
   end

   cmd_dec_t   dec;
   logic       is_rd;
   logic       acc;
   logic       can_load;
   logic [7:0] cur_addr;
   logic [7:0] rd_byte;

   nibcmd_decode u_dec (
      .cmd_byte (cmd_data),
      .dec      (dec)
   );

   assign is_rd     = dec.rd | dec.rd_inc;
   assign cmd_ready = !is_rd || can_load;
   assign acc       = cmd_valid && cmd_ready;

   nibcmd_assembler #(.IDX_W(IDX_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .dec      (dec),
      .acc      (acc),
      .cur_addr (cur_addr),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data)
   );

   assign rd_addr = cur_addr;

   nibcmd_pos_window #(
      .POS_W      (POS_W),
      .POS_BASE   (POS_BASE),
      .POS_ENABLE (POS_ENABLE)
   ) u_win (
      .addr      (cur_addr),
      .trig_pos  (trig_pos),
      .stop_pos  (stop_pos),
      .file_data (rd_data),
      .byte_out  (rd_byte)
   );

   nibcmd_out_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc && is_rd),
      .load_data (rd_byte),
      .out_ready (out_ready),
      .can_load  (can_load),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R8
   stall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_ready |-> (out_valid && !out_ready));

   // R5
   read_presents_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && is_rd) |=> out_valid);

   // R3
   write_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cmd_valid && !out_valid) || (cmd_valid && cmd_ready));

endmodule

// File: tb/nibcmd_regif_tb.sv
module nibcmd_regif_tb;

   localparam int       IDX_W    = 3;
   localparam int       POS_W    = 24;
   localparam bit [7:0] POS_BASE = 8'h08;
   localparam logic [23:0] TRIG = 24'hA1B2C3;
   localparam logic [23:0] STOP = 24'h0D0E0F;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [7:0]       cmd_data = 8'h00;
   logic             cmd_ready;
   logic             wr_en;
   logic [7:0]       wr_addr;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_data;
   logic [7:0]       rd_addr;
   logic [7:0]       rd_data;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [7:0]       out_data;

   logic [7:0] mem [256];

   always #5 clk = ~clk;

   nibcmd_regif #(.IDX_W(IDX_W), .POS_W(POS_W), .POS_BASE(POS_BASE)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trig_pos(TRIG), .stop_pos(STOP), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data)
   );

   assign rd_data = mem[rd_addr];
   always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference model state
   logic [7:0] m_addr = 8'h00;
   logic [3:0] m_lo = 4'h0;
   int         m_idx = 0;
   bit         m_ov = 1'b0;
   logic [7:0] m_od = 8'h00;
   string      m_tag = "R5";

   task automatic chk(string req, bit ok, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(logic [7:0] a);
      int off = int'(a) - int'(POS_BASE);
      if (off >= 0 && off < 3) return TRIG[8*off +: 8];
      if (off >= 3 && off < 6) return STOP[8*(off-3) +: 8];
      return mem[a];
   endfunction

   task automatic cyc(bit v, logic [7:0] d, bit ordy);
      logic [3:0] op;
      bit is_rd, exp_rdy, acc, exp_wr;
      @(negedge clk);
      cmd_valid = v; cmd_data = d; out_ready = ordy;
      #1;
      op = d[7:4];
      is_rd = (op == 4'h4) || (op == 4'h5);
      chk("R8", out_valid == m_ov, out_valid, m_ov);
      if (m_ov) chk(m_tag, out_data == m_od, out_data, m_od);
      exp_rdy = !is_rd || !m_ov || ordy;
      if (v) begin
         if (is_rd) chk("R8", cmd_ready == exp_rdy, cmd_ready, exp_rdy);
         else       chk("R10", cmd_ready == 1'b1, cmd_ready, 1);
      end
      acc = v && exp_rdy;
      exp_wr = acc && (op == 4'h3);
      chk("R3", wr_en == exp_wr, wr_en, exp_wr);
      if (exp_wr) begin
         chk("R2", wr_addr == m_addr, wr_addr, m_addr);
         chk("R3", wr_data == {d[3:0], m_lo}, wr_data, {d[3:0], m_lo});
         chk("R4", int'(wr_idx) == m_idx, wr_idx, m_idx);
      end
      chk("R7", rd_addr == m_addr, rd_addr, m_addr);
      if (m_ov && ordy) m_ov = 1'b0;
      if (acc) begin
         case (op)
            4'h0: m_addr[3:0] = d[3:0];
            4'h1: begin m_addr[7:4] = d[3:0]; m_idx = 0; end
            4'h2: m_lo = d[3:0];
            4'h3: m_idx = (m_idx + 1) % (1 << IDX_W);
            4'h4, 4'h5: begin
               m_ov = 1'b1;
               m_od = exp_byte(m_addr);
               m_tag = (m_addr >= POS_BASE && m_addr < POS_BASE + 8'd6) ? "R7" :
                       (op == 4'h5) ? "R6" : "R5";
               if (op == 4'h5) m_addr = m_addr + 8'd1;
            end
            default: ; // R9: no model effect
         endcase
      end
   endtask

   task automatic set_addr(logic [7:0] a);
      cyc(1'b1, {4'h0, a[3:0]}, 1'b1);
      cyc(1'b1, {4'h1, a[7:4]}, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      // R1 reset state
      chk("R1", out_valid == 1'b0, out_valid, 0);
      chk("R1", wr_en == 1'b0, wr_en, 0);
      chk("R1", cmd_ready == 1'b1, cmd_ready, 1);
      rst_n = 1'b1;

      // R2 R3 R4: two-byte write to 0x21, then read back
      set_addr(8'h21);
      cyc(1'b1, 8'h25, 1'b1); cyc(1'b1, 8'h3A, 1'b1);
      cyc(1'b1, 8'h2C, 1'b1); cyc(1'b1, 8'h3F, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);
      // R2: change only the low half
      cyc(1'b1, 8'h03, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);

      // R7 R6: six auto-increment reads back to back
      set_addr(POS_BASE);
      for (int k = 0; k < 6; k++) cyc(1'b1, 8'h50, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);   // next address comes from the file
      cyc(1'b0, 8'h00, 1'b1);

      // R8 R10: stall with pending read, non-read commands still accepted
      set_addr(8'h30);
      cyc(1'b1, 8'h50, 1'b0);
      cyc(1'b1, 8'h50, 1'b0);
      cyc(1'b1, 8'h50, 1'b0);
      cyc(1'b1, 8'h24, 1'b0);
      cyc(1'b1, 8'h37, 1'b0);
      cyc(1'b1, 8'h50, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);

      // R9: undefined opcodes leave everything untouched
      set_addr(8'h44);
      cyc(1'b1, 8'h6F, 1'b1); cyc(1'b1, 8'hF3, 1'b1); cyc(1'b1, 8'h9A, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);

      // R6: address wrap 0xFF -> 0x00
      set_addr(8'hFF);
      cyc(1'b1, 8'h50, 1'b1);
      cyc(1'b1, 8'h40, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);

      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] op;
         int r = int'($urandom_range(0, 15));
         op = (r < 13) ? 4'(r % 6) : 4'(6 + (r % 10));
         cyc(($urandom_range(0, 3) != 0), {op, 4'($urandom_range(0, 15))},
             ($urandom_range(0, 2) != 0));
      end
      cyc(1'b0, 8'h00, 1'b1);
      cyc(1'b0, 8'h00, 1'b1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule